// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt RAM

This block is a small synchronous dual-port RAM with a doorbell mechanism built on its two highest word addresses. Each of the two ports (left and right) owns one of those words as its inbox. When one port writes into the other port's inbox, an active-low interrupt line toward the receiving port goes low. The receiving port drops the interrupt again by reading its own inbox. The inbox words stay ordinary storage, so the message byte is whatever software puts there.

Each port has an active-low select, write strobe and output enable, an address, write data, registered read data (one cycle of latency) and an active-low busy input. A low busy input on the port that performs an access blocks the flag change that access would cause. The RAM array is not affected by busy. Depth and data width are parameters. The inbox locations follow the depth automatically: the left inbox is at DEPTH-2 and the right inbox is at DEPTH-1.

Top module: `mbox_irq_dpram`

## Requirements
- R1: While reset is held and after it is released, both interrupt outputs are high (inactive) and both read-data outputs are 0.
- R2: A right-port write (select low, write strobe low, busy high) to address DEPTH-2 drives `l_irq_n` low from the clock edge that takes the write.
- R3: A left-port write with the same conditions to address DEPTH-1 drives `r_irq_n` low from the clock edge that takes the write.
- R4: A left access with select and output enable low to DEPTH-2 sets `l_irq_n` high at that edge, whatever the write strobe is. A right access of the same kind to DEPTH-1 does the same for `r_irq_n`.
- R5: A write takes effect only when select and the write strobe are both low. With select high, a low write strobe stores nothing and changes no interrupt.
- R6: When the acting port's busy input is low, its inbox write does not set the peer's interrupt and its inbox read does not clear its own interrupt. The RAM contents are still written.
- R7: Every word, including both inbox words, stores data. A read (select and output enable low, write strobe high) presents the word on that port's read data one cycle later, and either port can read what the other wrote.
- R8: If a set and a clear of the same interrupt happen in the same cycle, the interrupt ends low (set wins).
- R9: A port writing its own inbox, or reading the peer's inbox, changes neither interrupt.
- R10: If both ports write the same address in the same cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_sel_n | input | 1 | Left select, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left busy, low blocks left-caused flag changes |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered |
| l_irq_n | output | 1 | Left interrupt, active low, driven both ways |
| r_sel_n | input | 1 | Right select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right busy, low blocks right-caused flag changes |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered |
| r_irq_n | output | 1 | Right interrupt, active low, driven both ways |

## Verification
The doorbell is tested by writing each inbox from the correct peer and then clearing it with a plain read. A second clear uses a read with the write strobe also low. This shows that clearing depends on the output enable and not on the read/write line. Other tests send near-miss patterns: a write strobe without select, each port touching its own inbox or the peer's inbox the wrong way, and accesses with busy low. In each case the interrupt must stay put, so these separate correct address and side decoding from decoding that is too loose. A cycle in which a set and a clear of the same interrupt meet checks the priority. Simultaneous writes to one address and cross-port reads check the storage side.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  typedef struct packed {
    logic wr;    // array write this cycle
    logic rd;    // array read this cycle
    logic post;  // qualified write into the peer inbox
    logic take;  // qualified read of own inbox
  } port_ev_t;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mbox_port_dec.sv
module mbox_port_dec #(
  parameter int            ADDR_W = 5,
  parameter mbox_pkg::side_e SIDE = mbox_pkg::SIDE_L
) (
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output mbox_pkg::port_ev_t ev
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] MB_L = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] MB_R = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] own_mb;
  logic [ADDR_W-1:0] peer_mb;

  generate
    if (SIDE == mbox_pkg::SIDE_L) begin : g_left
      assign own_mb  = MB_L;
      assign peer_mb = MB_R;
    end else begin : g_right
      assign own_mb  = MB_R;
      assign peer_mb = MB_L;
    end
  endgenerate

  logic wr_act;
  logic oe_act;

  always_comb begin
    wr_act  = !sel_n && !wr_n;
    oe_act  = !sel_n && !oe_n;
    ev.wr   = wr_act;
    ev.rd   = oe_act && wr_n;
    ev.post = wr_act && busy_n && (addr == peer_mb);
    ev.take = oe_act && busy_n && (addr == own_mb);
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr) pend_d = 1'b0;
    if (set) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign irq_n = !pend_q;
endmodule

// File: rtl/mbox_ram.sv
module mbox_ram #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_we,
  input  logic              l_re,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_we,
  input  logic              r_re,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Right first, left last: left data lands on a same-address collision.
  always_ff @(posedge clk) begin
    if (r_we) mem[r_addr] <= r_wdata;
    if (l_we) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_re) l_rdata <= mem[l_addr];
      if (r_re) r_rdata <= mem[r_addr];
    end
  end
endmodule

// File: rtl/mbox_irq_dpram.sv
module mbox_irq_dpram #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_wr_n,
  input  logic              l_oe_n,
  input  logic              l_busy_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_sel_n,
  input  logic              r_wr_n,
  input  logic              r_oe_n,
  input  logic              r_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);
  logic sys_rst_n;
  mbox_pkg::port_ev_t l_ev;
  mbox_pkg::port_ev_t r_ev;

  mbox_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (sys_rst_n)
  );

  mbox_port_dec #(.ADDR_W(ADDR_W), .SIDE(mbox_pkg::SIDE_L)) u_dec_l (
    .sel_n (l_sel_n), .wr_n (l_wr_n), .oe_n (l_oe_n),
    .busy_n(l_busy_n), .addr (l_addr), .ev (l_ev)
  );

  mbox_port_dec #(.ADDR_W(ADDR_W), .SIDE(mbox_pkg::SIDE_R)) u_dec_r (
    .sel_n (r_sel_n), .wr_n (r_wr_n), .oe_n (r_oe_n),
    .busy_n(r_busy_n), .addr (r_addr), .ev (r_ev)
  );

  // Left flag: raised by the right side, lowered by the left side.
  mbox_flag u_flag_l (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .set   (r_ev.post),
    .clr   (l_ev.take),
    .irq_n (l_irq_n)
  );

  mbox_flag u_flag_r (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .set   (l_ev.post),
    .clr   (r_ev.take),
    .irq_n (r_irq_n)
  );

  mbox_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .l_we    (l_ev.wr),
    .l_re    (l_ev.rd),
    .l_addr  (l_addr),
    .l_wdata (l_wdata),
    .l_rdata (l_rdata),
    .r_we    (r_ev.wr),
    .r_re    (r_ev.rd),
    .r_addr  (r_addr),
    .r_wdata (r_wdata),
    .r_rdata (r_rdata)
  );
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              srst_n,
  input logic              l_sel_n,
  input logic              l_wr_n,
  input logic              l_oe_n,
  input logic              l_busy_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_irq_n,
  input logic              r_sel_n,
  input logic              r_wr_n,
  input logic              r_oe_n,
  input logic              r_busy_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_irq_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BOX_L = ADDR_W'(DEPTH - 2);
  localparam logic [ADDR_W-1:0] BOX_R = ADDR_W'(DEPTH - 1);

  logic ring_l, ring_r, ack_l, ack_r;
  assign ring_l = !r_sel_n && !r_wr_n && r_busy_n && (r_addr == BOX_L);
  assign ring_r = !l_sel_n && !l_wr_n && l_busy_n && (l_addr == BOX_R);
  assign ack_l  = !l_sel_n && !l_oe_n && l_busy_n && (l_addr == BOX_L);
  assign ack_r  = !r_sel_n && !r_oe_n && r_busy_n && (r_addr == BOX_R);

  // R1
  p_reset_idle_r1: assert property (@(posedge clk) !srst_n |-> (l_irq_n && r_irq_n));

  p_left_set_r2: assert property (@(posedge clk) disable iff (!srst_n)
    ring_l |=> !l_irq_n);

  p_right_set_r3: assert property (@(posedge clk) disable iff (!srst_n)
    ring_r |=> !r_irq_n);

  p_left_clear_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (ack_l && !ring_l) |=> l_irq_n);

  p_right_clear_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (ack_r && !ring_r) |=> r_irq_n);

  // R5, R6, R9: anything that is neither a qualified ring nor ack leaves the flag alone
  p_left_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!ring_l && !ack_l) |=> $stable(l_irq_n));

  p_right_hold_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!ring_r && !ack_r) |=> $stable(r_irq_n));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (ring_l && ack_l) |=> !l_irq_n);
endmodule

bind mbox_irq_dpram mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .srst_n   (sys_rst_n),
  .l_sel_n  (l_sel_n),
  .l_wr_n   (l_wr_n),
  .l_oe_n   (l_oe_n),
  .l_busy_n (l_busy_n),
  .l_addr   (l_addr),
  .l_irq_n  (l_irq_n),
  .r_sel_n  (r_sel_n),
  .r_wr_n   (r_wr_n),
  .r_oe_n   (r_oe_n),
  .r_busy_n (r_busy_n),
  .r_addr   (r_addr),
  .r_irq_n  (r_irq_n)
);

// File: tb/mbox_irq_dpram_test.sv
module mbox_irq_dpram_test;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam logic [AW-1:0] BOX_L = 5'd30;
  localparam logic [AW-1:0] BOX_R = 5'd31;

  logic clk, rst_n;
  logic l_sel_n, l_wr_n, l_oe_n, l_busy_n;
  logic r_sel_n, r_wr_n, r_oe_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  mbox_irq_dpram #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_sel_n = 1; l_wr_n = 1; l_oe_n = 1; l_busy_n = 1; l_addr = '0; l_wdata = '0;
    r_sel_n = 1; r_wr_n = 1; r_oe_n = 1; r_busy_n = 1; r_addr = '0; r_wdata = '0;
  endtask

  // Inputs are set on a falling edge; the next rising edge takes them.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lwr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic bsy_n);
    l_sel_n = 0; l_wr_n = 0; l_addr = a; l_wdata = d; l_busy_n = bsy_n;
    step(); idle();
  endtask

  task automatic rwr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic bsy_n);
    r_sel_n = 0; r_wr_n = 0; r_addr = a; r_wdata = d; r_busy_n = bsy_n;
    step(); idle();
  endtask

  task automatic lrd(input logic [AW-1:0] a, input logic bsy_n, output logic [DW-1:0] d);
    l_sel_n = 0; l_oe_n = 0; l_addr = a; l_busy_n = bsy_n;
    step(); d = l_rdata; idle();
  endtask

  task automatic rrd(input logic [AW-1:0] a, input logic bsy_n, output logic [DW-1:0] d);
    r_sel_n = 0; r_oe_n = 0; r_addr = a; r_busy_n = bsy_n;
    step(); d = r_rdata; idle();
  endtask

  task automatic t_reset();
    chk("R1 l_irq_n", l_irq_n, 1);
    chk("R1 r_irq_n", r_irq_n, 1);
    chk("R1 l_rdata", l_rdata, 0);
    chk("R1 r_rdata", r_rdata, 0);
  endtask

  task automatic t_left_doorbell();
    logic [DW-1:0] d;
    rwr(BOX_L, 8'hA5, 1);
    chk("R2 l_irq_n after right post", l_irq_n, 0);
    chk("R2 r_irq_n untouched", r_irq_n, 1);
    lrd(BOX_L, 1, d);
    chk("R7 left inbox data", d, 8'hA5);
    chk("R4 l_irq_n cleared by read", l_irq_n, 1);
  endtask

  task automatic t_right_doorbell();
    logic [DW-1:0] d;
    lwr(BOX_R, 8'h3C, 1);
    chk("R3 r_irq_n after left post", r_irq_n, 0);
    // Clear with the write strobe also low: output enable decides.
    r_sel_n = 0; r_oe_n = 0; r_wr_n = 0; r_addr = BOX_R; r_wdata = 8'h77;
    step(); idle();
    chk("R4 r_irq_n cleared, strobe low", r_irq_n, 1);
    chk("R9 own inbox write leaves l_irq_n", l_irq_n, 1);
    lrd(BOX_R, 1, d);
    chk("R7 right inbox holds data", d, 8'h77);
  endtask

  task automatic t_strobe();
    logic [DW-1:0] d;
    r_sel_n = 1; r_wr_n = 0; r_addr = BOX_L; r_wdata = 8'h11;
    step(); idle();
    chk("R5 no select, no interrupt", l_irq_n, 1);
    lrd(BOX_L, 1, d);
    chk("R5 no select, no store", d, 8'hA5);
  endtask

  task automatic t_busy();
    logic [DW-1:0] d;
    rwr(BOX_L, 8'h42, 0);
    chk("R6 busy blocks set", l_irq_n, 1);
    lrd(BOX_L, 1, d);
    chk("R6 busy still stores", d, 8'h42);
    rwr(BOX_L, 8'h43, 1);
    chk("R2 set before busy clear", l_irq_n, 0);
    lrd(BOX_L, 0, d);
    chk("R6 busy blocks clear", l_irq_n, 0);
    lrd(BOX_L, 1, d);
    chk("R4 clear after busy released", l_irq_n, 1);
  endtask

  task automatic t_set_wins();
    rwr(BOX_L, 8'h50, 1);
    r_sel_n = 0; r_wr_n = 0; r_addr = BOX_L; r_wdata = 8'h51;
    l_sel_n = 0; l_oe_n = 0; l_addr = BOX_L;
    step(); idle();
    chk("R8 set wins over clear", l_irq_n, 0);
    l_sel_n = 0; l_oe_n = 0; l_addr = BOX_L;
    step(); idle();
    chk("R8 later clear works", l_irq_n, 1);
  endtask

  task automatic t_wrong_side();
    logic [DW-1:0] d;
    lwr(BOX_L, 8'h01, 1);
    chk("R9 left writing own inbox", l_irq_n, 1);
    chk("R9 left writing own inbox, right flag", r_irq_n, 1);
    lwr(BOX_R, 8'h02, 1);
    chk("R3 right flag set", r_irq_n, 0);
    lrd(BOX_R, 1, d);
    chk("R9 left reading peer inbox keeps r_irq_n", r_irq_n, 0);
    rrd(BOX_L, 1, d);
    chk("R9 right reading left inbox keeps r_irq_n", r_irq_n, 0);
    rrd(BOX_R, 1, d);
    chk("R4 right read clears", r_irq_n, 1);
    chk("R7 right reads left-written inbox", d, 8'h02);
  endtask

  task automatic t_storage();
    logic [DW-1:0] d;
    for (int i = 0; i < 4; i++) lwr(AW'(i), DW'(8'h10 + i), 1);
    for (int i = 0; i < 4; i++) begin
      rrd(AW'(i), 1, d);
      chk("R7 cross-port read", d, 8'h10 + i);
    end
    chk("R9 plain writes leave flags", {l_irq_n, r_irq_n}, 2'b11);
    l_sel_n = 0; l_wr_n = 0; l_addr = 5'd5; l_wdata = 8'hAA;
    r_sel_n = 0; r_wr_n = 0; r_addr = 5'd5; r_wdata = 8'h55;
    step(); idle();
    lrd(5'd5, 1, d);
    chk("R10 collision keeps left data (left read)", d, 8'hAA);
    rrd(5'd5, 1, d);
    chk("R10 collision keeps left data (right read)", d, 8'hAA);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_left_doorbell();
    t_right_doorbell();
    t_strobe();
    t_busy();
    t_set_wins();
    t_wrong_side();
    t_storage();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule